// File: doc/BRIEF.md
# Flash Command Sequencer

This block runs one short flash command at a time: status reads, identification reads, write enable, erase and similar single-shot operations. Software loads a 32-bit address, up to eight bytes of outgoing payload and one packed control word. Setting the execute bit in the control word starts the command. The sequencer then issues the opcode, the optional address bytes, any dummy clocks and the outgoing or incoming payload bytes, one item at a time, to a serial shifter. While the command runs, an in-progress flag reads high. Incoming bytes land in two read-data words, where software collects them once the flag drops.

The shifter is a separate block that handles clock generation and pin timing. It accepts one item per request/acknowledge handshake. Each item is either a byte to send, a single dummy clock, or a byte to receive.

The state machine has six states: `ST_IDLE`, `ST_OPCODE`, `ST_ADDR`, `ST_DUMMY`, `ST_WRITE` and `ST_READ`.
- An accepted execute moves `ST_IDLE` to `ST_OPCODE`.
- When the last item of a phase is acknowledged, the machine moves to the first enabled later phase, in the order `ST_ADDR`, `ST_DUMMY`, `ST_WRITE`, `ST_READ`.
- If no later phase is enabled, it returns to `ST_IDLE`.
- Inside a phase, each acknowledge that is not the last one only advances the item counter.

Top module: `flash_cmd_engine`

## Requirements
- R1: The control word (select 0) holds these fields, each of which reads back as written:
  - opcode at bits 31:24
  - read enable at 23, read count at 22:20
  - address enable at 19, address count at 17:16
  - write enable at 15, write count at 14:12
  - dummy count at 11:7

  Bit 1 reads the in-progress flag. Bit 0 (execute), bit 18 and bits 6:2 read as zero.
- R2: Items are issued in the fixed order: opcode, address bytes, dummy clocks, write bytes, read bytes. A command with no enable bits set issues the opcode alone.
- R3: With address enable set, the engine sends (address count + 1) bytes from the address register (select 1), most significant byte first. For a count of n bytes, the first byte is bits 8n-1:8n-8.
- R4: The engine issues exactly dummy-count dummy items (kind 1). Dummy items and read items (kind 2) drive a zero transmit byte.
- R5: With write enable set, the engine sends (write count + 1) bytes as kind-0 items. Byte k comes from bits 8k+7:8k of the 64-bit payload formed by write-data high (select 3) above write-data low (select 2). Byte 0 is sent first.
- R6: With read enable set, the engine receives (read count + 1) bytes. Received byte k is placed at bits 8k+7:8k of read-data high (select 5) above read-data low (select 4). Both read words are cleared when a command starts, so bytes that are not received read as zero.
- R7: The in-progress flag rises on the clock edge that accepts an execute. It falls on the edge that accepts the final item, and the last received byte is stored on that same edge.
- R8: While a command is in progress, every register write is ignored. This includes a second execute, so no extra command follows.
- R9: A request stays high, with unchanged kind and transmit byte, until it is acknowledged. Exactly one item completes per cycle in which both request and acknowledge are high.
- R10: The read-data words cannot be written. A write to select 4 or 5 leaves their contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read-back of the selected register |
| xfer_req | output | 1 | Item request to the shifter |
| xfer_kind | output | 2 | Item kind: 0 transmit, 1 dummy clock, 2 receive |
| xfer_tx | output | 8 | Byte to transmit |
| xfer_ack | input | 1 | Shifter completes the current item |
| xfer_rxd | input | 8 | Received byte, valid with the acknowledge |
| cs_active | output | 1 | Device select held for the whole command |

## Verification
The hardest case to reach from the ports is a register write that arrives mid-command. Such a write can corrupt the address or payload that is being shifted, or restart the machine.

The bench holds the engine busy for a long time with a four-byte address and the full 31 dummy clocks. It then writes a new opcode with execute set, a new address and new payload while the command is still in flight. It checks three things:
- the item stream still matches the original command;
- the read-back values are the original ones;
- no request appears afterwards.

The shifter model varies its acknowledge delay from zero to two cycles, so back-to-back acknowledges and stalled requests both occur within one command.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
    localparam int WORD_W    = 32;
    localparam int PAY_BYTES = 8;
    localparam int PAY_W     = 8 * PAY_BYTES;
    localparam int PAY_IDX_W = $clog2(PAY_BYTES);
    localparam int DUM_W     = 5;
    localparam int ITEM_W    = DUM_W;

    localparam logic [2:0] SEL_CTRL = 3'd0;
    localparam logic [2:0] SEL_ADDR = 3'd1;
    localparam logic [2:0] SEL_WLO  = 3'd2;
    localparam logic [2:0] SEL_WHI  = 3'd3;
    localparam logic [2:0] SEL_RLO  = 3'd4;
    localparam logic [2:0] SEL_RHI  = 3'd5;

    localparam logic [1:0] XK_TX    = 2'd0;
    localparam logic [1:0] XK_DUMMY = 2'd1;
    localparam logic [1:0] XK_RX    = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPCODE, ST_ADDR, ST_DUMMY, ST_WRITE, ST_READ
    } seq_state_t;

    typedef struct packed {
        logic [7:0]       opcode;
        logic             rd_en;
        logic [2:0]       rd_cnt;
        logic             addr_en;
        logic [1:0]       addr_cnt;
        logic             wr_en;
        logic [2:0]       wr_cnt;
        logic [DUM_W-1:0] dummy;
    } cmd_cfg_t;
endpackage

// File: rtl/fce_regs.sv
module fce_regs
    import flash_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        sel,
    input  logic [WORD_W-1:0] wdata_in,
    input  logic              busy,
    output cmd_cfg_t          cfg,
    output logic [WORD_W-1:0] addr,
    output logic [PAY_W-1:0]  payload,
    output logic              start
);
    logic accept;
    assign accept = wr_en && !busy;
    assign start  = accept && (sel == SEL_CTRL) && wdata_in[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg     <= '0;
            addr    <= '0;
            payload <= '0;
        end else if (accept) begin
            case (sel)
                SEL_CTRL: begin
                    cfg.opcode   <= wdata_in[31:24];
                    cfg.rd_en    <= wdata_in[23];
                    cfg.rd_cnt   <= wdata_in[22:20];
                    cfg.addr_en  <= wdata_in[19];
                    cfg.addr_cnt <= wdata_in[17:16];
                    cfg.wr_en    <= wdata_in[15];
                    cfg.wr_cnt   <= wdata_in[14:12];
                    cfg.dummy    <= wdata_in[11:7];
                end
                SEL_ADDR: addr                  <= wdata_in;
                SEL_WLO:  payload[WORD_W-1:0]   <= wdata_in;
                SEL_WHI:  payload[PAY_W-1:WORD_W] <= wdata_in;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fce_rx_collect.sv
module fce_rx_collect
    import flash_cmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 rx_we,
    input  logic [PAY_IDX_W-1:0] rx_idx,
    input  logic [7:0]           rx_byte,
    output logic [PAY_W-1:0]     rdata
);
    for (genvar i = 0; i < PAY_BYTES; i++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rdata[8*i +: 8] <= '0;
            else if (clear)
                rdata[8*i +: 8] <= '0;
            else if (rx_we && (rx_idx == PAY_IDX_W'(i)))
                rdata[8*i +: 8] <= rx_byte;
        end
    end
endmodule

// File: rtl/fce_seq.sv
module fce_seq
    import flash_cmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  cmd_cfg_t             cfg,
    input  logic [WORD_W-1:0]    addr,
    input  logic [PAY_W-1:0]     payload,
    input  logic                 xfer_ack,
    input  logic [7:0]           xfer_rxd,
    output logic                 xfer_req,
    output logic [1:0]           xfer_kind,
    output logic [7:0]           xfer_tx,
    output logic                 busy,
    output logic                 rx_we,
    output logic [PAY_IDX_W-1:0] rx_idx,
    output logic [7:0]           rx_byte
);
    seq_state_t        state_q, state_d;
    logic [ITEM_W-1:0] cnt_q, cnt_d;
    logic              last;
    logic [1:0]        ab_sel;
    logic [WORD_W-1:0] addr_sh;
    logic [PAY_W-1:0]  pay_sh;

    function automatic seq_state_t next_phase(seq_state_t s, cmd_cfg_t c);
        logic to_addr, to_dummy, to_write, to_read;
        to_addr  = (s == ST_OPCODE) && c.addr_en;
        to_dummy = (s inside {ST_OPCODE, ST_ADDR}) && (c.dummy != '0);
        to_write = (s inside {ST_OPCODE, ST_ADDR, ST_DUMMY}) && c.wr_en;
        to_read  = (s != ST_READ) && c.rd_en;
        if (to_addr)       return ST_ADDR;
        else if (to_dummy) return ST_DUMMY;
        else if (to_write) return ST_WRITE;
        else if (to_read)  return ST_READ;
        else               return ST_IDLE;
    endfunction

    always_comb begin
        unique case (state_q)
            ST_OPCODE: last = 1'b1;
            ST_ADDR:   last = (cnt_q == ITEM_W'(cfg.addr_cnt));
            ST_DUMMY:  last = (cnt_q == cfg.dummy - 1'b1);
            ST_WRITE:  last = (cnt_q == ITEM_W'(cfg.wr_cnt));
            ST_READ:   last = (cnt_q == ITEM_W'(cfg.rd_cnt));
            default:   last = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (state_q == ST_IDLE) begin
            cnt_d = '0;
            if (start) state_d = ST_OPCODE;
        end else if (xfer_ack) begin
            if (last) begin
                state_d = next_phase(state_q, cfg);
                cnt_d   = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign ab_sel  = cfg.addr_cnt - cnt_q[1:0];
    assign addr_sh = addr >> {ab_sel, 3'b000};
    assign pay_sh  = payload >> {cnt_q[PAY_IDX_W-1:0], 3'b000};

    always_comb begin
        xfer_req  = (state_q != ST_IDLE);
        busy      = (state_q != ST_IDLE);
        xfer_kind = XK_TX;
        xfer_tx   = '0;
        unique case (state_q)
            ST_OPCODE: xfer_tx   = cfg.opcode;
            ST_ADDR:   xfer_tx   = addr_sh[7:0];
            ST_DUMMY:  xfer_kind = XK_DUMMY;
            ST_WRITE:  xfer_tx   = pay_sh[7:0];
            ST_READ:   xfer_kind = XK_RX;
            default: ;
        endcase
        rx_we   = (state_q == ST_READ) && xfer_ack;
        rx_idx  = cnt_q[PAY_IDX_W-1:0];
        rx_byte = xfer_rxd;
    end
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
    import flash_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [2:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        xfer_req,
    output logic [1:0]  xfer_kind,
    output logic [7:0]  xfer_tx,
    input  logic        xfer_ack,
    input  logic [7:0]  xfer_rxd,
    output logic        cs_active
);
    cmd_cfg_t             cfg;
    logic [WORD_W-1:0]    addr;
    logic [PAY_W-1:0]     payload;
    logic [PAY_W-1:0]     rdata;
    logic                 start;
    logic                 busy;
    logic                 rx_we;
    logic [PAY_IDX_W-1:0] rx_idx;
    logic [7:0]           rx_byte;

    fce_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .sel(reg_sel),
        .wdata_in(reg_wdata), .busy(busy), .cfg(cfg), .addr(addr),
        .payload(payload), .start(start)
    );

    fce_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg(cfg), .addr(addr),
        .payload(payload), .xfer_ack(xfer_ack), .xfer_rxd(xfer_rxd),
        .xfer_req(xfer_req), .xfer_kind(xfer_kind), .xfer_tx(xfer_tx),
        .busy(busy), .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte)
    );

    fce_rx_collect u_rx (
        .clk(clk), .rst_n(rst_n), .clear(start), .rx_we(rx_we),
        .rx_idx(rx_idx), .rx_byte(rx_byte), .rdata(rdata)
    );

    assign cs_active = busy;

    always_comb begin
        case (reg_sel)
            SEL_CTRL: reg_rdata = {cfg.opcode, cfg.rd_en, cfg.rd_cnt, cfg.addr_en,
                                   1'b0, cfg.addr_cnt, cfg.wr_en, cfg.wr_cnt,
                                   cfg.dummy, 5'b00000, busy, 1'b0};
            SEL_ADDR: reg_rdata = addr;
            SEL_WLO:  reg_rdata = payload[WORD_W-1:0];
            SEL_WHI:  reg_rdata = payload[PAY_W-1:WORD_W];
            SEL_RLO:  reg_rdata = rdata[WORD_W-1:0];
            SEL_RHI:  reg_rdata = rdata[PAY_W-1:WORD_W];
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fce_checker.sv
module fce_checker
    import flash_cmd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_req,
    input logic             xfer_ack,
    input logic [1:0]       xfer_kind,
    input logic [7:0]       xfer_tx,
    input logic             busy,
    input logic             start,
    input cmd_cfg_t         cfg,
    input logic [PAY_W-1:0] rdata
);
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_kind) && $stable(xfer_tx)));

    a_r4_quiet_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_kind != XK_TX) |-> (xfer_tx == 8'h00));

    a_r7_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg));

    a_r6_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(rdata));
endmodule

bind flash_cmd_engine fce_checker chk_i (
    .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .xfer_ack(xfer_ack),
    .xfer_kind(xfer_kind), .xfer_tx(xfer_tx), .busy(busy), .start(start),
    .cfg(cfg), .rdata(rdata)
);

// File: tb/flash_cmd_engine_tb_top.sv
module flash_cmd_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        xfer_req;
    logic [1:0]  xfer_kind;
    logic [7:0]  xfer_tx;
    logic        xfer_ack;
    logic [7:0]  xfer_rxd;
    logic        cs_active;

    int checks = 0;
    int fails = 0;
    int log_n = 0;
    int seed = 0;
    logic [1:0] log_kind [0:63];
    logic [7:0] log_byte [0:63];
    logic [1:0] exp_kind [0:63];
    logic [7:0] exp_byte [0:63];
    int exp_n;
    int rx_base;

    always #5 clk = ~clk;

    flash_cmd_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_req(xfer_req),
        .xfer_kind(xfer_kind), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack),
        .xfer_rxd(xfer_rxd), .cs_active(cs_active)
    );

    function automatic logic [7:0] rxb(int idx);
        return 8'h5A ^ 8'(idx * 29) ^ 8'(seed);
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Shifter model: acknowledges each item after 0..2 cycles.
    initial begin
        xfer_ack = 1'b0;
        xfer_rxd = '0;
        forever begin
            @(negedge clk);
            xfer_ack = 1'b0;
            if (xfer_req) begin
                if (log_n < 64) begin
                    log_kind[log_n] = xfer_kind;
                    log_byte[log_n] = xfer_tx;
                end
                repeat ((log_n + seed) % 3) @(negedge clk);
                xfer_ack = 1'b1;
                xfer_rxd = rxb(log_n);
                log_n++;
            end
        end
    end

    task automatic reg_write(logic [2:0] s, logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(logic [2:0] s, output logic [31:0] d);
        reg_sel = s;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] ctrl_word(logic [7:0] op, int a, int d, int w, int r, bit ex);
        logic [31:0] c;
        c = {op, 24'h0};
        if (r > 0) c = c | 32'h0080_0000 | (32'(r - 1) << 20);
        if (a > 0) c = c | 32'h0008_0000 | (32'(a - 1) << 16);
        if (w > 0) c = c | 32'h0000_8000 | (32'(w - 1) << 12);
        c = c | (32'(d & 31) << 7) | 32'(ex);
        return c;
    endfunction

    task automatic push(logic [1:0] k, logic [7:0] b);
        exp_kind[exp_n] = k; exp_byte[exp_n] = b; exp_n++;
    endtask

    task automatic build_exp(logic [7:0] op, int a, int d, int w, int r,
                             logic [31:0] av, logic [63:0] wv);
        exp_n = 0;
        push(2'd0, op);
        for (int i = 0; i < a; i++) push(2'd0, 8'(av >> (8 * (a - 1 - i))));
        for (int i = 0; i < d; i++) push(2'd1, 8'h00);
        for (int i = 0; i < w; i++) push(2'd0, 8'(wv >> (8 * i)));
        for (int i = 0; i < r; i++) push(2'd2, 8'h00);
        rx_base = 1 + a + d + w;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            reg_read(3'd0, v);
            if (!v[1]) break;
        end
    endtask

    task automatic compare_log(int a, int d, int w, int r);
        string tag;
        logic [63:0] er;
        logic [31:0] v;
        chk(log_n == exp_n, "R2 item count", 64'(log_n), 64'(exp_n));
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            if (i == 0) tag = "R2 opcode first";
            else if (i < 1 + a) tag = "R3 address byte";
            else if (i < 1 + a + d) tag = "R4 dummy item";
            else if (i < 1 + a + d + w) tag = "R5 write byte";
            else tag = "R6 read item";
            chk({log_kind[i], log_byte[i]} == {exp_kind[i], exp_byte[i]}, tag,
                64'({log_kind[i], log_byte[i]}), 64'({exp_kind[i], exp_byte[i]}));
        end
        er = '0;
        for (int k = 0; k < r; k++) er[8*k +: 8] = rxb(rx_base + k);
        reg_read(3'd4, v);
        chk(v == er[31:0], "R6 read-data low", 64'(v), 64'(er[31:0]));
        reg_read(3'd5, v);
        chk(v == er[63:32], "R6 read-data high", 64'(v), 64'(er[63:32]));
    endtask

    task automatic run_cmd(logic [7:0] op, int a, int d, int w, int r);
        logic [31:0] av, v;
        logic [63:0] wv;
        av = 32'h8000_0001 ^ (32'(seed) * 32'h01F3_5B27);
        wv = {32'hC3A5_0F96 ^ 32'(seed * 77), 32'h1234_5678 + 32'(seed * 3)};
        reg_write(3'd1, av);
        reg_write(3'd2, wv[31:0]);
        reg_write(3'd3, wv[63:32]);
        build_exp(op, a, d, w, r, av, wv);
        log_n = 0;
        reg_write(3'd0, ctrl_word(op, a, d, w, r, 1'b1));
        reg_read(3'd0, v);
        chk(v[1] == 1'b1, "R7 busy after execute", 64'(v[1]), 64'd1);
        wait_idle();
        compare_log(a, d, w, r);
        reg_read(3'd0, v);
        chk(v == ctrl_word(op, a, d, w, r, 1'b0), "R1 control read-back",
            64'(v), 64'(ctrl_word(op, a, d, w, r, 1'b0)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int sv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reg_read(3'd0, v);
        chk(v == 32'h0, "R1 reset control", 64'(v), 64'h0);
        chk(xfer_req == 1'b0 && cs_active == 1'b0, "R9 reset no request",
            64'({xfer_req, cs_active}), 64'h0);
        reg_read(3'd4, v);
        chk(v == 32'h0, "R6 reset read-data", 64'(v), 64'h0);

        // Opcode-only command (write-enable style)
        seed = 1;
        run_cmd(8'h06, 0, 0, 0, 0);

        // Near-exhaustive sweep of address, write and read lengths
        for (int a = 0; a <= 4; a++)
            for (int w = 0; w <= 8; w++)
                for (int r = 0; r <= 8; r++) begin
                    seed = a * 81 + w * 9 + r + 2;
                    run_cmd(8'(8'h0B + seed), a, (a * 5 + w * 3 + r * 7) % 32, w, r);
                end

        // R10: read-data words are not writable
        seed = 500;
        run_cmd(8'h9F, 0, 0, 0, 8);
        reg_write(3'd4, 32'hFFFF_FFFF);
        reg_write(3'd5, 32'h0000_0000);
        reg_read(3'd4, v);
        chk(v == {rxb(4), rxb(3), rxb(2), rxb(1)}, "R10 read-data low unchanged",
            64'(v), 64'({rxb(4), rxb(3), rxb(2), rxb(1)}));
        reg_read(3'd5, v);
        chk(v == {rxb(8), rxb(7), rxb(6), rxb(5)}, "R10 read-data high unchanged",
            64'(v), 64'({rxb(8), rxb(7), rxb(6), rxb(5)}));

        // R8: writes during a long command are ignored
        seed = 600;
        reg_write(3'd1, 32'hA1B2_C3D4);
        reg_write(3'd2, 32'h5566_7788);
        reg_write(3'd3, 32'h0);
        build_exp(8'hEB, 4, 31, 2, 3, 32'hA1B2_C3D4, 64'h5566_7788);
        log_n = 0;
        reg_write(3'd0, ctrl_word(8'hEB, 4, 31, 2, 3, 1'b1));
        repeat (10) @(negedge clk);
        reg_write(3'd0, ctrl_word(8'h33, 0, 0, 1, 0, 1'b1));
        reg_write(3'd1, 32'h0BAD_0BAD);
        reg_write(3'd2, 32'hDEAD_BEEF);
        wait_idle();
        compare_log(4, 31, 2, 3);
        reg_read(3'd0, v);
        chk(v == ctrl_word(8'hEB, 4, 31, 2, 3, 1'b0), "R8 control kept",
            64'(v), 64'(ctrl_word(8'hEB, 4, 31, 2, 3, 1'b0)));
        reg_read(3'd1, v);
        chk(v == 32'hA1B2_C3D4, "R8 address kept", 64'(v), 64'hA1B2_C3D4);
        reg_read(3'd2, v);
        chk(v == 32'h5566_7788, "R8 write-data kept", 64'(v), 64'h5566_7788);
        sv = log_n;
        repeat (20) @(negedge clk);
        chk(log_n == sv && !xfer_req, "R8 no second command", 64'(log_n), 64'(sv));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule